// File: doc/BRIEF.md
# Four-Tap Shift-Chain FIR Filter

This block is a four-tap finite impulse response filter arranged as a multiply-adder. Each new signed sample enters the first stage of a sample shift chain. On every edge of the sample clock, the samples already in the chain move one stage further along. Each of the four chain stages is multiplied by its own signed coefficient. The four products are summed and registered on the sample clock. The output is therefore the convolution of the most recent four samples with the coefficient set.

The coefficients are held in a separate bank of registers clocked by a second clock, the coefficient clock. On a rising edge of that clock, all four words on the parallel coefficient bus are captured together, but only while the load enable is high. Each register group can be tied to one of two synchronous active-low clears, or to neither, through a parameter. By default the sample chain and the output follow clear 0, and the coefficient bank follows clear 1. Coefficients should be changed only while the sample stream is idle or flushed, because the bank crosses into the sample domain without synchronisers.

Top module: `fir4_shift_mac`

## Requirements
- R1: After every sample clock edge, `y_out` equals the signed sum over i = 0..3 of tap(i) × coef(i), where tap(i) is the chain stage i and coef(i) is bus word i (bits i*CW+CW-1 down to i*CW), both as they stood just before that edge.
- R2: A sample enters stage 0 on a sample clock edge and advances one stage per edge. An isolated value 1 followed by zeros therefore produces coef(0), coef(1), coef(2) and coef(3) on successive outputs.
- R3: A sample captured on a given edge first contributes to `y_out` after the following sample clock edge. This is a latency of one sample clock.
- R4: `y_out` is SW+CW+2 bits wide, two's complement, and never wraps. This holds for the most negative inputs: all samples and coefficients at -2^(SW-1) give +4·2^(SW-1)·2^(CW-1).
- R5: On a rising coefficient clock edge with `coef_ld_en` high, all four coefficient words are captured from `coef_bus` at once.
- R6: With `coef_ld_en` low, `coef_bus` is ignored and the previously loaded coefficients stay in use.
- R7: While the data clear (default `clr0_n`, active low, sampled on the sample clock) is low, the chain stages and `y_out` become zero.
- R8: While the coefficient clear (default `clr1_n`, active low, sampled on the coefficient clock) is low, all coefficients become zero, so every later output is zero until a new load.
- R9: The data clear leaves the coefficient bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sample clock for the chain and the output register |
| clr0_n | input | 1 | Clear 0, synchronous, active low |
| clk_coef | input | 1 | Coefficient clock |
| clr1_n | input | 1 | Clear 1, synchronous, active low |
| coef_ld_en | input | 1 | Coefficient load enable |
| coef_bus | input | NTAPS*CW | Four signed coefficient words; word i sits at bits i*CW+CW-1 down to i*CW |
| smp_in | input | SW | Signed input sample |
| y_out | output | SW+CW+2 | Signed filter result |

## Verification
The hardest situation to reach from the ports is a coefficient change. The bank runs on its own clock, so the sample chain keeps shifting while a load is in flight, and the outputs around that moment mix old and new coefficients. The stimulus handles this in a fixed order: it performs each load or refused load first, then flushes the chain with a data clear, and only then compares. Every comparison therefore covers one settled coefficient set against a chain content that is known. Impulses after each load expose the order of the coefficient words. Runs of the most negative samples against the most negative and most positive coefficients push the sum to both extremes of the output range.

// File: rtl/fir4_pkg.sv
`timescale 1ns/1ps
// Shared types for the four-tap shift-chain filter.
// Assumes: clears are active low; "none" means the group is never cleared.
package fir4_pkg;

    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_SEL0 = 2'd1,
        CLR_SEL1 = 2'd2
    } clr_sel_e;

    // Returns the active-low clear a register group follows.
    function automatic logic pick_clr(input clr_sel_e sel, input logic c0, input logic c1);
        case (sel)
            CLR_SEL0: return c0;
            CLR_SEL1: return c1;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/fir4_coef_bank.sv
`timescale 1ns/1ps
// Coefficient register bank: captures all NTAPS words in parallel on the
// coefficient clock when the load enable is high.
// Assumes: the consumer in the other clock domain reads these only while
// they are stable (no load in flight).
module fir4_coef_bank #(
    parameter int NTAPS = 4,
    parameter int CW    = 8
) (
    input  logic                  clk_coef,
    input  logic                  clr_n,
    input  logic                  ld_en,
    input  logic [NTAPS*CW-1:0]   coef_bus,
    output logic [NTAPS*CW-1:0]   coef_flat
);

    for (genvar i = 0; i < NTAPS; i++) begin : g_word
        logic [CW-1:0] word_q;

        // Clear the word, or load it from the bus while enabled.
        always_ff @(posedge clk_coef) begin
            if (!clr_n)
                word_q <= '0;
            else if (ld_en)
                word_q <= coef_bus[i*CW +: CW];
        end

        assign coef_flat[i*CW +: CW] = word_q;
    end

endmodule

// File: rtl/fir4_shift_chain.sv
`timescale 1ns/1ps
// Sample shift chain: stage 0 takes the input, stage i takes stage i-1,
// one step per sample clock edge.
// Assumes: synchronous active-low clear zeroes every stage.
module fir4_shift_chain #(
    parameter int NTAPS = 4,
    parameter int SW    = 8
) (
    input  logic                 clk_smp,
    input  logic                 clr_n,
    input  logic [SW-1:0]        smp_in,
    output logic [NTAPS*SW-1:0]  tap_flat
);

    for (genvar i = 0; i < NTAPS; i++) begin : g_stage
        logic [SW-1:0] stage_q;
        logic [SW-1:0] stage_d;

        if (i == 0) begin : g_head
            assign stage_d = smp_in;
        end else begin : g_body
            assign stage_d = tap_flat[(i-1)*SW +: SW];
        end

        // Advance the chain by one stage, or clear it.
        always_ff @(posedge clk_smp) begin
            if (!clr_n)
                stage_q <= '0;
            else
                stage_q <= stage_d;
        end

        assign tap_flat[i*SW +: SW] = stage_q;
    end

endmodule

// File: rtl/fir4_mac_tree.sv
`timescale 1ns/1ps
// Signed products of each stage with its coefficient, summed at full
// width and registered on the sample clock.
// Assumes: output width SW+CW+clog2(NTAPS) holds any sum without wrap.
module fir4_mac_tree #(
    parameter int NTAPS = 4,
    parameter int SW    = 8,
    parameter int CW    = 8
) (
    input  logic                                   clk_smp,
    input  logic                                   clr_n,
    input  logic [NTAPS*SW-1:0]                    tap_flat,
    input  logic [NTAPS*CW-1:0]                    coef_flat,
    output logic signed [SW+CW+$clog2(NTAPS)-1:0]  y_q
);

    localparam int PW = SW + CW;
    localparam int OW = PW + $clog2(NTAPS);

    logic signed [PW-1:0] prod [NTAPS];
    logic signed [OW-1:0] acc;

    for (genvar i = 0; i < NTAPS; i++) begin : g_mul
        logic signed [SW-1:0] a_s;
        logic signed [CW-1:0] b_s;
        assign a_s     = tap_flat[i*SW +: SW];
        assign b_s     = coef_flat[i*CW +: CW];
        assign prod[i] = PW'(a_s) * PW'(b_s);
    end

    // Sum all sign-extended products.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++)
            acc = acc + OW'(prod[i]);
    end

    // Register the sum, or clear it.
    always_ff @(posedge clk_smp) begin
        if (!clr_n)
            y_q <= '0;
        else
            y_q <= acc;
    end

endmodule

// File: rtl/fir4_shift_mac.sv
`timescale 1ns/1ps
// Four-tap shift-chain FIR filter top: sample chain and output on the
// sample clock, parallel-loaded coefficient bank on the coefficient clock.
// Assumes: coefficients change only while the sample stream is idle.
module fir4_shift_mac #(
    parameter int                 NTAPS    = 4,
    parameter int                 SW       = 8,
    parameter int                 CW       = 8,
    parameter fir4_pkg::clr_sel_e DATA_CLR = fir4_pkg::CLR_SEL0,
    parameter fir4_pkg::clr_sel_e COEF_CLR = fir4_pkg::CLR_SEL1
) (
    input  logic                                   clk_smp,
    input  logic                                   clr0_n,
    input  logic                                   clk_coef,
    input  logic                                   clr1_n,
    input  logic                                   coef_ld_en,
    input  logic [NTAPS*CW-1:0]                    coef_bus,
    input  logic [SW-1:0]                          smp_in,
    output logic signed [SW+CW+$clog2(NTAPS)-1:0]  y_out
);

    logic                  data_clr_n;
    logic                  coef_clr_n;
    logic [NTAPS*SW-1:0]   tap_flat;
    logic [NTAPS*CW-1:0]   coef_flat;

    assign data_clr_n = fir4_pkg::pick_clr(DATA_CLR, clr0_n, clr1_n);
    assign coef_clr_n = fir4_pkg::pick_clr(COEF_CLR, clr0_n, clr1_n);

    fir4_coef_bank #(.NTAPS(NTAPS), .CW(CW)) u_coef (
        .clk_coef  (clk_coef),
        .clr_n     (coef_clr_n),
        .ld_en     (coef_ld_en),
        .coef_bus  (coef_bus),
        .coef_flat (coef_flat)
    );

    fir4_shift_chain #(.NTAPS(NTAPS), .SW(SW)) u_chain (
        .clk_smp  (clk_smp),
        .clr_n    (data_clr_n),
        .smp_in   (smp_in),
        .tap_flat (tap_flat)
    );

    fir4_mac_tree #(.NTAPS(NTAPS), .SW(SW), .CW(CW)) u_mac (
        .clk_smp   (clk_smp),
        .clr_n     (data_clr_n),
        .tap_flat  (tap_flat),
        .coef_flat (coef_flat),
        .y_q       (y_out)
    );

endmodule

// File: rtl/fir4_shift_mac_chk.sv
`timescale 1ns/1ps
// Checker for the four-tap filter: chain movement, clears and coefficient
// loading, attached to the top module by bind.
module fir4_shift_mac_chk #(
    parameter int NTAPS = 4,
    parameter int SW    = 8,
    parameter int CW    = 8
) (
    input logic                                   clk_smp,
    input logic                                   clk_coef,
    input logic                                   dclr_n,
    input logic                                   cclr_n,
    input logic                                   coef_ld_en,
    input logic [NTAPS*CW-1:0]                    coef_bus,
    input logic [SW-1:0]                          smp_in,
    input logic [NTAPS*SW-1:0]                    tap_flat,
    input logic [NTAPS*CW-1:0]                    coef_flat,
    input logic signed [SW+CW+$clog2(NTAPS)-1:0]  y_out
);

    // R2
    head_capture_chk: assert property (@(posedge clk_smp) disable iff (!dclr_n)
        $past(dclr_n) |-> tap_flat[SW-1:0] == $past(smp_in));

    // R2
    chain_shift_chk: assert property (@(posedge clk_smp) disable iff (!dclr_n)
        $past(dclr_n) |-> tap_flat[NTAPS*SW-1:SW] == $past(tap_flat[(NTAPS-1)*SW-1:0]));

    // R7
    data_clear_chk: assert property (@(posedge clk_smp) disable iff (!dclr_n)
        $rose(dclr_n) |-> (y_out == '0 && tap_flat == '0));

    // R5
    coef_load_chk: assert property (@(posedge clk_coef) disable iff (!cclr_n)
        ($past(coef_ld_en) && $past(cclr_n)) |-> coef_flat == $past(coef_bus));

    // R6
    coef_hold_chk: assert property (@(posedge clk_coef) disable iff (!cclr_n)
        (!$past(coef_ld_en) && $past(cclr_n)) |-> coef_flat == $past(coef_flat));

    // R8
    coef_clear_chk: assert property (@(posedge clk_coef) disable iff (!cclr_n)
        $rose(cclr_n) |-> coef_flat == '0);

endmodule

bind fir4_shift_mac fir4_shift_mac_chk #(.NTAPS(NTAPS), .SW(SW), .CW(CW)) u_chk (
    .clk_smp    (clk_smp),
    .clk_coef   (clk_coef),
    .dclr_n     (data_clr_n),
    .cclr_n     (coef_clr_n),
    .coef_ld_en (coef_ld_en),
    .coef_bus   (coef_bus),
    .smp_in     (smp_in),
    .tap_flat   (tap_flat),
    .coef_flat  (coef_flat),
    .y_out      (y_out)
);

// File: tb/fir4_shift_mac_bench.sv
`timescale 1ns/1ps
// Self-checking bench: arithmetic convolution model, coefficient sweeps,
// impulses, extremes and clears.
module fir4_shift_mac_bench;

    localparam int NT = 4;
    localparam int SW = 8;
    localparam int CW = 8;
    localparam int OW = SW + CW + 2;

    logic                clk_smp = 1'b0;
    logic                clk_coef = 1'b0;
    logic                clr0_n = 1'b0;
    logic                clr1_n = 1'b0;
    logic                coef_ld_en = 1'b0;
    logic [NT*CW-1:0]    coef_bus = '0;
    logic [SW-1:0]       smp_in = '0;
    logic signed [OW-1:0] y_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int hist [NT];
    int cf [NT];

    always #4 clk_smp = ~clk_smp;
    always #6 clk_coef = ~clk_coef;

    fir4_shift_mac #(.NTAPS(NT), .SW(SW), .CW(CW)) u_fir4_shift_mac (
        .clk_smp    (clk_smp),
        .clr0_n     (clr0_n),
        .clk_coef   (clk_coef),
        .clr1_n     (clr1_n),
        .coef_ld_en (coef_ld_en),
        .coef_bus   (coef_bus),
        .smp_in     (smp_in),
        .y_out      (y_out)
    );

    task automatic check(input int got, input int exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One sample clock: model output from current chain, then shift.
    task automatic tick(input int x, input bit chk, input string req);
        int exp;
        smp_in = x[SW-1:0];
        exp = 0;
        for (int i = 0; i < NT; i++) exp += hist[i] * cf[i];
        for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        @(posedge clk_smp); #1;
        if (chk) check(int'(y_out), exp, req);
    endtask

    // Data clear for one sample edge; chain and output become zero.
    task automatic data_clear(input string req);
        clr0_n = 1'b0;
        smp_in = 8'h5A;
        @(posedge clk_smp); #1;
        clr0_n = 1'b1;
        for (int i = 0; i < NT; i++) hist[i] = 0;
        check(int'(y_out), 0, req);
    endtask

    task automatic load(input int c0, input int c1, input int c2, input int c3, input bit en);
        int c [NT];
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        @(negedge clk_coef);
        for (int i = 0; i < NT; i++) coef_bus[i*CW +: CW] = c[i][CW-1:0];
        coef_ld_en = en;
        @(posedge clk_coef); #1;
        coef_ld_en = 1'b0;
        if (en) for (int i = 0; i < NT; i++) cf[i] = c[i];
        @(posedge clk_smp); #1;
    endtask

    task automatic impulse(input string req);
        data_clear(req);
        tick(1, 1'b1, req);
        for (int k = 0; k < NT + 1; k++) tick(0, 1'b1, req);
    endtask

    task automatic rand_run(input int n, input string req);
        data_clear(req);
        for (int k = 0; k < n; k++) tick(int'($urandom_range(0, 255)) - 128, 1'b1, req);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) begin hist[i] = 0; cf[i] = 0; end
        repeat (3) @(posedge clk_coef);
        #1;
        clr1_n = 1'b1;
        @(posedge clk_smp); #1;
        // R7 reset state of the output
        check(int'(y_out), 0, "R7 reset");
        clr0_n = 1'b1;
        // R8 coefficients cleared at start: outputs stay zero
        for (int k = 0; k < 6; k++) tick(100 - k * 37, 1'b1, "R8 reset coef");

        // R5 parallel load, R2 order via impulse
        load(3, -5, 7, -11, 1'b1);
        impulse("R2 R5 impulse");
        // R3 latency: first output after a capture ignores it
        data_clear("R3");
        tick(-9, 1'b1, "R3 before");
        tick(0, 1'b1, "R3 after");

        // R6 load refused with enable low
        load(50, 60, 70, 80, 1'b0);
        impulse("R6 refused load");
        // R9 data clear keeps coefficients
        data_clear("R9");
        tick(2, 1'b1, "R9");
        tick(0, 1'b1, "R9");

        // R4 extremes
        load(-128, -128, -128, -128, 1'b1);
        data_clear("R4");
        for (int k = 0; k < 6; k++) tick(-128, 1'b1, "R4 max positive");
        load(127, 127, 127, 127, 1'b1);
        data_clear("R4");
        for (int k = 0; k < 6; k++) tick(-128, 1'b1, "R4 max negative");

        // R1 sweep across coefficient sets
        for (int s = 0; s < 24; s++) begin
            load(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                 int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128, 1'b1);
            rand_run(300, "R1 random");
        end
        load(-128, 127, -1, 1, 1'b1);
        impulse("R1 R2 mixed");
        data_clear("R1");
        for (int x = -128; x < 128; x++) tick(x, 1'b1, "R1 ramp");

        // R8 coefficient clear mid-run
        @(negedge clk_coef);
        clr1_n = 1'b0;
        @(posedge clk_coef); #1;
        clr1_n = 1'b1;
        for (int i = 0; i < NT; i++) cf[i] = 0;
        rand_run(20, "R8 cleared coef");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule